// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three 16-bit down-counters behind a byte-wide register bus. Software writes a control byte to pick a channel and the way that channel's data port handles bytes: low byte only, high byte only, or low then high. It then loads the reload divider through the channel's data port, and it reads the running count back through the same port in the same byte pattern. In the paired pattern, reads and writes share one toggle that says which byte comes next.

A counter counts only while it is enabled and its gate is active. Only channel 1 has its gate tied active. Channels 0 and 2 can be loaded and read, but they hold their count. Each enabled, gated counter steps down once per `tick` pulse. When it reaches 1, the next tick reloads it from the divider and emits a one-cycle terminal pulse. Terminal pulses from channel 1 set a sticky clock interrupt unless `inhibit` is high. A read of the clear register returns zero and drops the interrupt.

Top module: `pit_three_channel`

## Requirements
- R1: A write to the control word (byte address 0x0C) whose bits 7:6 name channel 0, 1 or 2 stores the whole byte as that channel's mode, clears its enable and sets its toggle to "low byte next". If bits 7:6 are 3, nothing changes.
- R2: Mode bits 5:4 select the access pattern: 01 is low-only and 10 is high-only. In these patterns a data write (channel n at byte address 4·n) replaces that byte of the divider and keeps the other byte. It then copies the divider into the count and sets enable.
- R3: With pattern 11, the first data write replaces the low byte and copies the divider into the count, but does not enable. The second write replaces the high byte, reloads the count and enables. Each write flips the toggle.
- R4: A data read returns the count in the channel's pattern one cycle later. With pattern 11 it returns the low byte when the toggle is clear and the high byte when it is set, and it flips the same toggle that writes use. With pattern 00, reads return 0 and writes are ignored.
- R5: An enabled channel 1 counts down by one per `tick`. Channels 0 and 2 never count.
- R6: When the count is 1 or less, a tick reloads the divider and pulses that channel's `tc_pulse` bit for one cycle. A divider of N gives one pulse every N ticks, and a divider of 0 gives a pulse on every tick.
- R7: A channel 1 terminal event sets `irq` when `inhibit` is low and leaves `irq` unchanged when `inhibit` is high. `irq` then stays set.
- R8: A read of the clear register (byte address 0x10) returns 0 and clears `irq`. A write to that register has no effect.
- R9: After reset, `irq`, `tc_pulse` and `rdata` are 0, and every mode, divider, count, enable and toggle is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Byte address; bits 4:2 pick the register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid the cycle after `rd_en` |
| tick | input | 1 | Count enable, one step per high cycle |
| inhibit | input | 1 | Suppresses interrupt setting when high |
| irq | output | 1 | Sticky clock interrupt |
| tc_pulse | output | 3 | One-cycle terminal pulse per channel |

## Verification
The paired byte mode is the hardest state to reach from the ports, because reads and writes share one toggle. The stimulus makes a single low-byte write and then a read. That read must return the high byte, must leave the channel still disabled across several ticks, and must bring the sequence back to "low next". A second hard case is an invalid channel select that arrives while a channel is running. The bench shows it changes nothing by counting terminal pulses after the write.

// File: rtl/pit_pkg.sv
// Shared constants and types for the three-channel interval timer.
// Assumes byte-wide registers on a word-aligned map (address bits 1:0 unused).
package pit_pkg;
    localparam int BYTE_W  = 8;
    localparam int COUNT_W = 2 * BYTE_W;

    // Word indices (byte address bits 4:2).
    localparam logic [2:0] WORD_CTRL  = 3'd3;
    localparam logic [2:0] WORD_CLEAR = 3'd4;

    typedef enum logic [1:0] {
        ACC_NONE = 2'b00,
        ACC_LO   = 2'b01,
        ACC_HI   = 2'b10,
        ACC_PAIR = 2'b11
    } access_e;
endpackage

// File: rtl/pit_decode.sv
// Register decode: turns a bus access into one strobe per channel.
// Assumes NUM_CH <= 3 so that the channel select fits in wdata[7:6].
module pit_decode #(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 5
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [NUM_CH-1:0] ctrl_we,
    output logic [NUM_CH-1:0] data_we,
    output logic [NUM_CH-1:0] data_re,
    output logic              clear_re
);
    import pit_pkg::*;

    logic [2:0] word;
    assign word = addr[4:2];

    // Clear-register read strobe.
    assign clear_re = rd_en && (word == WORD_CLEAR);

    // One set of strobes per channel.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
        assign data_we[i] = wr_en && (word == 3'(i));
        assign data_re[i] = rd_en && (word == 3'(i));
        assign ctrl_we[i] = wr_en && (word == WORD_CTRL) && (wdata[7:6] == 2'(i));
    end
endmodule

// File: rtl/pit_channel.sv
// One 16-bit down-counter with its mode byte, divider, enable and byte toggle.
// Bus strobes take priority over counting within a cycle. GATE_ON ties the gate.
module pit_channel #(
    parameter bit GATE_ON = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_we,
    input  logic       data_we,
    input  logic       data_re,
    input  logic [7:0] wbyte,
    input  logic       tick,
    output logic [7:0] rbyte,
    output logic       wrap,
    output logic       tc
);
    import pit_pkg::*;

    logic [7:0]         mode_q;
    logic [COUNT_W-1:0] div_q, cnt_q, div_nx;
    logic               en_q, tog_q;
    logic               step;
    access_e            acc;

    assign acc = access_e'(mode_q[5:4]);

    // Divider after merging the written byte.
    always_comb begin
        div_nx = div_q;
        unique case (acc)
            ACC_LO:   div_nx[7:0]  = wbyte;
            ACC_HI:   div_nx[15:8] = wbyte;
            ACC_PAIR: if (tog_q) div_nx[15:8] = wbyte; else div_nx[7:0] = wbyte;
            default:  ;
        endcase
    end

    // Count step and terminal event, both blocked by any bus write.
    assign step = tick && en_q && GATE_ON && !ctrl_we && !data_we;
    assign wrap = step && (cnt_q <= COUNT_W'(1));

    // Read byte chosen by the access pattern.
    always_comb begin
        unique case (acc)
            ACC_LO:   rbyte = cnt_q[7:0];
            ACC_HI:   rbyte = cnt_q[15:8];
            ACC_PAIR: rbyte = tog_q ? cnt_q[15:8] : cnt_q[7:0];
            default:  rbyte = '0;
        endcase
    end

    // Mode, divider, count, enable and toggle state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            div_q  <= '0;
            cnt_q  <= '0;
            en_q   <= 1'b0;
            tog_q  <= 1'b0;
        end else if (ctrl_we) begin
            mode_q <= wbyte;
            en_q   <= 1'b0;
            tog_q  <= 1'b0;
        end else if (data_we) begin
            if (acc != ACC_NONE) begin
                div_q <= div_nx;
                cnt_q <= div_nx;
                if (acc == ACC_PAIR) begin
                    tog_q <= ~tog_q;
                    en_q  <= en_q | tog_q;
                end else begin
                    en_q  <= 1'b1;
                end
            end
        end else begin
            if (data_re && acc == ACC_PAIR) tog_q <= ~tog_q;
            if (step) cnt_q <= wrap ? div_q : cnt_q - COUNT_W'(1);
        end
    end

    // Registered terminal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) tc <= 1'b0;
        else        tc <= wrap;
    end
endmodule

// File: rtl/pit_three_channel.sv
// Top of the interval timer: decode, three channels, read mux and sticky interrupt.
// Assumes single-cycle strobes; rdata is registered and updates only on reads.
module pit_three_channel #(
    parameter int          NUM_CH    = 3,
    parameter int          ADDR_W    = 5,
    parameter int          IRQ_CH    = 1,
    parameter logic [2:0]  GATE_MASK = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              tick,
    input  logic              inhibit,
    output logic              irq,
    output logic [NUM_CH-1:0] tc_pulse
);
    logic [NUM_CH-1:0] ctrl_we, data_we, data_re, wrap;
    logic              clear_re;
    logic [7:0]        rbyte [NUM_CH];
    logic [7:0]        rd_mux;

    pit_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
        .ctrl_we(ctrl_we), .data_we(data_we), .data_re(data_re),
        .clear_re(clear_re)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        pit_channel #(.GATE_ON(GATE_MASK[i])) u_ch (
            .clk(clk), .rst_n(rst_n),
            .ctrl_we(ctrl_we[i]), .data_we(data_we[i]), .data_re(data_re[i]),
            .wbyte(wdata), .tick(tick),
            .rbyte(rbyte[i]), .wrap(wrap[i]), .tc(tc_pulse[i])
        );
    end

    // Read mux: the addressed channel's byte, zero for everything else.
    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++)
            if (data_re[i]) rd_mux = rbyte[i];
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    // Sticky interrupt: a new terminal event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                        irq <= 1'b0;
        else if (wrap[IRQ_CH] && !inhibit) irq <= 1'b1;
        else if (clear_re)                 irq <= 1'b0;
    end
endmodule

// File: rtl/pit_checker.sv
// Temporal checks on the interval timer ports, attached by bind.
module pit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [4:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic       tick,
    input logic       inhibit,
    input logic       irq,
    input logic [2:0] tc_pulse
);
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> tc_pulse[1]);
    p_irq_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> !$past(inhibit));
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 5'h10) |=> rdata == 8'h00);
    p_clear_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 5'h10 && !tick) |=> !irq);
    p_ctrl_stop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 5'h0C && wdata[7:6] == 2'd1) |=> !tc_pulse[1]);
    p_tc_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse != 3'b000) |-> $past(tick));
    p_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && tc_pulse == 3'b000 && rdata == 8'h00));
endmodule

bind pit_three_channel pit_checker u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick(tick), .inhibit(inhibit),
    .irq(irq), .tc_pulse(tc_pulse)
);

// File: tb/pit_three_channel_test.sv
// Directed bench for the interval timer: one task per scenario.
module pit_three_channel_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0, inhibit = 1'b0;
    logic [4:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    logic [2:0] tc_pulse;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] rv;
    int         np;

    always #10 clk = ~clk;

    pit_three_channel uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .inhibit(inhibit),
        .irq(irq), .tc_pulse(tc_pulse)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    // Apply n ticks and count channel pulses on the selected bit.
    task automatic run_ticks(input int n, input int ch, output int pulses);
        pulses = 0;
        tick = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (tc_pulse[ch]) pulses++;
        end
        tick = 1'b0;
    endtask

    task automatic t_reset;
        expect_eq("R9 irq", irq, 0);
        expect_eq("R9 tc_pulse", tc_pulse, 0);
        expect_eq("R9 rdata", rdata, 0);
        bus_rd(5'h04, rv);
        expect_eq("R9 ch1 read after reset", rv, 0);
    endtask

    task automatic t_single;
        bus_wr(5'h0C, 8'h50);            // ch1 low-only
        bus_wr(5'h04, 8'h34);
        bus_rd(5'h04, rv);
        expect_eq("R2 low-only read", rv, 8'h34);
        bus_wr(5'h0C, 8'h60);            // ch1 high-only
        bus_wr(5'h04, 8'h12);
        bus_rd(5'h04, rv);
        expect_eq("R2 high-only read", rv, 8'h12);
        bus_wr(5'h0C, 8'h50);
        bus_rd(5'h04, rv);
        expect_eq("R2 low byte kept", rv, 8'h34);
    endtask

    task automatic t_pair;
        bus_wr(5'h0C, 8'h70);            // ch1 low then high
        bus_wr(5'h04, 8'h05);            // divider 0x1205, not enabled
        run_ticks(3, 1, np);
        expect_eq("R3 no pulses before second byte", np, 0);
        bus_rd(5'h04, rv);               // shared toggle: high byte next
        expect_eq("R4 shared toggle read", rv, 8'h12);
        bus_wr(5'h0C, 8'h70);
        bus_wr(5'h04, 8'h05);
        bus_wr(5'h04, 8'h00);            // divider 0x0005, enabled
        bus_rd(5'h04, rv);
        expect_eq("R3 low byte", rv, 8'h05);
        bus_rd(5'h04, rv);
        expect_eq("R3 high byte", rv, 8'h00);
    endtask

    task automatic t_count;
        run_ticks(2, 1, np);
        bus_rd(5'h04, rv);
        expect_eq("R5 count after 2 ticks", rv, 8'h03);
        bus_rd(5'h04, rv);
        run_ticks(10, 1, np);
        expect_eq("R6 pulses in 10 ticks", np, 2);
        bus_rd(5'h04, rv);
        expect_eq("R6 count after reload", rv, 8'h03);
        bus_rd(5'h04, rv);
        expect_eq("R7 irq set", irq, 1);
    endtask

    task automatic t_clear;
        bus_wr(5'h10, 8'hFF);
        expect_eq("R8 write no effect", irq, 1);
        bus_rd(5'h10, rv);
        expect_eq("R8 clear read data", rv, 0);
        expect_eq("R8 irq cleared", irq, 0);
    endtask

    task automatic t_inhibit;
        inhibit = 1'b1;
        run_ticks(5, 1, np);
        expect_eq("R7 pulse while inhibited", np, 1);
        expect_eq("R7 irq stays low", irq, 0);
        inhibit = 1'b0;
    endtask

    task automatic t_zero;
        bus_wr(5'h0C, 8'h50);
        bus_wr(5'h04, 8'h00);            // divider 0
        run_ticks(4, 1, np);
        expect_eq("R6 zero divider pulses", np, 4);
        bus_wr(5'h0C, 8'hD0);            // select 3: ignored
        run_ticks(3, 1, np);
        expect_eq("R1 invalid select ignored", np, 3);
        bus_wr(5'h0C, 8'h50);            // disables ch1
        run_ticks(3, 1, np);
        expect_eq("R1 control write disables", np, 0);
    endtask

    task automatic t_mode0;
        bus_wr(5'h0C, 8'h60);
        bus_wr(5'h04, 8'h02);            // count 0x0200
        bus_wr(5'h0C, 8'h40);            // pattern 00
        bus_rd(5'h04, rv);
        expect_eq("R4 mode 00 read", rv, 0);
        bus_wr(5'h04, 8'h77);
        bus_wr(5'h0C, 8'h60);
        bus_rd(5'h04, rv);
        expect_eq("R4 mode 00 write ignored", rv, 8'h02);
    endtask

    task automatic t_gate;
        int p0, p2;
        bus_wr(5'h0C, 8'h10);            // ch0 low-only
        bus_wr(5'h00, 8'h07);
        run_ticks(5, 0, p0);
        bus_rd(5'h00, rv);
        expect_eq("R5 ch0 holds", rv, 8'h07);
        expect_eq("R5 ch0 no pulse", p0, 0);
        bus_wr(5'h0C, 8'hB0);            // ch2 low then high
        bus_wr(5'h08, 8'h03);
        bus_wr(5'h08, 8'h00);
        run_ticks(4, 2, p2);
        bus_rd(5'h08, rv);
        expect_eq("R5 ch2 holds", rv, 8'h03);
        expect_eq("R5 ch2 no pulse", p2, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_pair();
        t_count();
        t_clear();
        t_inhibit();
        t_zero();
        t_mode0();
        t_gate();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule